// File: doc/BRIEF.md
# Flag-Setting ALU with Condition Evaluator

This block is the execute-stage arithmetic unit of a small 32-bit processor. Two operands and a two-bit function select go in, and a result comes out through purely combinational logic. Four operations are supported: addition, subtraction (second operand minus first), bitwise AND and bitwise XOR. When the instruction asks for it, the zero, sign and overflow conditions of the result are captured into a three-bit flag register on the rising clock edge.

A separate three-bit condition code is checked against the stored flags and gives a single "take" output. The decode stage uses this output to decide whether a conditional register move is committed or a conditional branch is followed. The same six signed comparisons serve both instruction groups. One extra code means "always taken".

Top module: `exec_flag_alu`

## Requirements
- R1: With function select 0, `result` equals `op_a + op_b` modulo 2^32.
- R2: With function select 1, `result` equals `op_b - op_a` modulo 2^32.
- R3: With function select 2, `result` is `op_a & op_b`; with function select 3, it is `op_a ^ op_b`.
- R4: `result` follows changes of `op_a`, `op_b` and `alu_fn` without any clock edge.
- R5: While `rst_n` is low, and after it is released, the flags read ZF=1, SF=0, OF=0 until the first load.
- R6: At a rising edge with `set_cc` high, ZF is loaded with (result == 0) and SF with result bit 31.
- R7: At such a load, OF takes signed overflow: for add, operands of equal sign with a result of the other sign; for subtract, `op_b` and `op_a` of different sign with a result whose sign differs from `op_b`. For AND and XOR, OF is loaded with 0.
- R8: At a rising edge with `set_cc` low, all three flags keep their values.
- R9: `take` depends on `cond_fn` as follows. Code 0 gives 1. Code 1 (le) gives (SF^OF)|ZF. Code 2 (lt) gives SF^OF. Code 3 (eq) gives ZF. Code 4 (ne) gives !ZF. Code 5 (ge) gives !(SF^OF). Code 6 (gt) gives !((SF^OF)|ZF). Code 7 gives 0.
- R10: `take` is computed from the stored flags only. The result being produced in the same cycle does not affect it until a load has taken place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| op_a | input | 32 | First operand (subtrahend for subtract) |
| op_b | input | 32 | Second operand (minuend for subtract) |
| alu_fn | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| set_cc | input | 1 | Load the flags at the next rising edge |
| cond_fn | input | 3 | Condition code evaluated against the stored flags |
| result | output | 32 | Combinational operation result |
| flag_zf | output | 1 | Stored zero flag |
| flag_sf | output | 1 | Stored sign flag |
| flag_of | output | 1 | Stored overflow flag |
| take | output | 1 | Condition outcome for a move or branch |

## Verification
An operation that sets the flags and a condition evaluation often fall in the same cycle. In that cycle, `take` must reflect the flags from before the edge, and the new result must not leak through. The bench provokes this on every step: it sets a new operation and condition code together, judges `take` against its own model flags before the edge, and then updates that model only if `set_cc` was high. A directed case produces a zero result with loading disabled and checks that the equal predicate stays false. Random operands are mixed with the signed boundary values 0x7FFFFFFF and 0x80000000 for add and subtract.

// File: rtl/exec_alu_pkg.sv
`timescale 1ns/1ps
package exec_alu_pkg;

   localparam int FN_W   = 2;
   localparam int COND_W = 3;

   typedef enum logic [FN_W-1:0] {
      FN_ADD = 2'd0,
      FN_SUB = 2'd1,
      FN_AND = 2'd2,
      FN_XOR = 2'd3
   } alu_fn_t;

   typedef enum logic [COND_W-1:0] {
      CND_ALWAYS = 3'd0,
      CND_LE     = 3'd1,
      CND_LT     = 3'd2,
      CND_EQ     = 3'd3,
      CND_NE     = 3'd4,
      CND_GE     = 3'd5,
      CND_GT     = 3'd6,
      CND_NEVER  = 3'd7
   } cond_t;

   typedef struct packed {
      logic zf;
      logic sf;
      logic of;
   } flags_t;

   localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/exec_alu_core.sv
`timescale 1ns/1ps
module exec_alu_core
   import exec_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [FN_W-1:0]   fn,
   output logic [DATA_W-1:0] res,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("exec_alu_core: DATA_W must be at least 2");
   end

   alu_fn_t            fn_e;
   logic [DATA_W-1:0]  arith_res;
   logic               arith_ovf;

   assign fn_e = alu_fn_t'(fn);

   if (SHARED_ADDER) begin : g_shared
      logic              is_sub;
      logic [DATA_W-1:0] rhs;
      logic [DATA_W-1:0] sum;
      assign is_sub    = (fn_e == FN_SUB);
      assign rhs       = is_sub ? ~op_a : op_a;
      assign sum       = op_b + rhs + {{(DATA_W-1){1'b0}}, is_sub};
      assign arith_res = sum;
      assign arith_ovf = (op_b[MSB] == rhs[MSB]) && (sum[MSB] != op_b[MSB]);
   end else begin : g_split
      logic [DATA_W-1:0] add_r;
      logic [DATA_W-1:0] sub_r;
      logic              add_v;
      logic              sub_v;
      assign add_r = op_a + op_b;
      assign sub_r = op_b - op_a;
      assign add_v = (op_a[MSB] == op_b[MSB]) && (add_r[MSB] != op_a[MSB]);
      assign sub_v = (op_a[MSB] != op_b[MSB]) && (sub_r[MSB] != op_b[MSB]);
      assign arith_res = (fn_e == FN_SUB) ? sub_r : add_r;
      assign arith_ovf = (fn_e == FN_SUB) ? sub_v : add_v;
   end

   always_comb begin
      res = '0;
      ovf = 1'b0;
      unique case (fn_e)
         FN_ADD,
         FN_SUB: begin
            res = arith_res;
            ovf = arith_ovf;
         end
         FN_AND: res = op_a & op_b;
         FN_XOR: res = op_a ^ op_b;
         default: begin
            res = '0;
            ovf = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/exec_flag_reg.sv
`timescale 1ns/1ps
module exec_flag_reg
   import exec_alu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  flags_t nxt,
   output flags_t cur
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur <= FLAGS_RESET;
      end else if (load) begin
         cur <= nxt;
      end
   end
endmodule

// File: rtl/exec_cond_eval.sv
`timescale 1ns/1ps
module exec_cond_eval
   import exec_alu_pkg::*;
(
   input  logic [COND_W-1:0] cond,
   input  flags_t            fl,
   output logic              take
);
   logic lt_w;
   logic le_w;

   assign lt_w = fl.sf ^ fl.of;
   assign le_w = lt_w | fl.zf;

   always_comb begin
      unique case (cond_t'(cond))
         CND_ALWAYS: take = 1'b1;
         CND_LE:     take = le_w;
         CND_LT:     take = lt_w;
         CND_EQ:     take = fl.zf;
         CND_NE:     take = ~fl.zf;
         CND_GE:     take = ~lt_w;
         CND_GT:     take = ~le_w;
         default:    take = 1'b0;
      endcase
   end
endmodule

// File: rtl/exec_flag_alu.sv
`timescale 1ns/1ps
module exec_flag_alu
   import exec_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [1:0]        alu_fn,
   input  logic              set_cc,
   input  logic [2:0]        cond_fn,
   output logic [DATA_W-1:0] result,
   output logic              flag_zf,
   output logic              flag_sf,
   output logic              flag_of,
   output logic              take
);
   localparam int MSB = DATA_W - 1;

   logic   core_ovf;
   flags_t nxt_flags;
   flags_t cur_flags;

   exec_alu_core #(
      .DATA_W      (DATA_W),
      .SHARED_ADDER(SHARED_ADDER)
   ) u_core (
      .op_a (op_a),
      .op_b (op_b),
      .fn   (alu_fn),
      .res  (result),
      .ovf  (core_ovf)
   );

   assign nxt_flags.zf = ~|result;
   assign nxt_flags.sf = result[MSB];
   assign nxt_flags.of = core_ovf;

   exec_flag_reg u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .load (set_cc),
      .nxt  (nxt_flags),
      .cur  (cur_flags)
   );

   exec_cond_eval u_cond (
      .cond(cond_fn),
      .fl  (cur_flags),
      .take(take)
   );

   assign flag_zf = cur_flags.zf;
   assign flag_sf = cur_flags.sf;
   assign flag_of = cur_flags.of;

endmodule

// File: rtl/exec_flag_alu_chk.sv
`timescale 1ns/1ps
module exec_flag_alu_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        alu_fn,
   input logic              set_cc,
   input logic [2:0]        cond_fn,
   input logic [DATA_W-1:0] result,
   input logic              flag_zf,
   input logic              flag_sf,
   input logic              flag_of,
   input logic              take
);
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !set_cc |=> $stable({flag_zf, flag_sf, flag_of})); // R8

   AST_ZF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      set_cc |=> (flag_zf == ($past(result) == '0))); // R6

   AST_SF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      set_cc |=> (flag_sf == $past(result[DATA_W-1]))); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (set_cc && alu_fn[1]) |=> !flag_of); // R7

   AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_fn == 3'd0) |-> take); // R9

   AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_fn == 3'd7) |-> !take); // R9

   AST_EQ_FROM_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_fn == 3'd3) |-> (take == flag_zf)); // R10

   AST_LT_FROM_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_fn == 3'd2) |-> (take == (flag_sf ^ flag_of))); // R10
endmodule

bind exec_flag_alu exec_flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .alu_fn (alu_fn),
   .set_cc (set_cc),
   .cond_fn(cond_fn),
   .result (result),
   .flag_zf(flag_zf),
   .flag_sf(flag_sf),
   .flag_of(flag_of),
   .take   (take)
);

// File: tb/sim_exec_flag_alu.sv
`timescale 1ns/1ps
module sim_exec_flag_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [1:0]  alu_fn = '0;
   logic        set_cc = 1'b0;
   logic [2:0]  cond_fn = '0;
   logic [31:0] result;
   logic        flag_zf, flag_sf, flag_of, take;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic m_zf = 1'b1, m_sf = 1'b0, m_of = 1'b0;

   always #2 clk = ~clk;

   exec_flag_alu u0 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .alu_fn(alu_fn),
      .set_cc(set_cc), .cond_fn(cond_fn), .result(result),
      .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of), .take(take)
   );

   function automatic logic [31:0] ref_res(input logic [31:0] a, b, input logic [1:0] f);
      case (f)
         2'd0:    return a + b;
         2'd1:    return b - a;
         2'd2:    return a & b;
         default: return a ^ b;
      endcase
   endfunction

   function automatic logic ref_of(input logic [31:0] a, b, input logic [1:0] f);
      logic [31:0] r;
      r = ref_res(a, b, f);
      if (f == 2'd0) return (a[31] == b[31]) && (r[31] != a[31]);
      if (f == 2'd1) return (a[31] != b[31]) && (r[31] != b[31]);
      return 1'b0;
   endfunction

   function automatic logic ref_take(input logic [2:0] c, input logic z, s, o);
      case (c)
         3'd0:    return 1'b1;
         3'd1:    return (s ^ o) | z;
         3'd2:    return s ^ o;
         3'd3:    return z;
         3'd4:    return ~z;
         3'd5:    return ~(s ^ o);
         3'd6:    return ~((s ^ o) | z);
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [1:0] f,
                       input logic sc, input logic [2:0] c);
      logic [31:0] er;
      string       rq;
      @(negedge clk);
      op_a = a; op_b = b; alu_fn = f; set_cc = sc; cond_fn = c;
      #1;
      er = ref_res(a, b, f);
      rq = (f == 2'd0) ? "R1" : (f == 2'd1) ? "R2" : "R3";
      chk(result == er, rq, result, er);
      chk(take == ref_take(c, m_zf, m_sf, m_of), "R9 R10", {31'd0, take},
          {31'd0, ref_take(c, m_zf, m_sf, m_of)});
      @(posedge clk);
      #1;
      if (sc) begin
         m_zf = (er == 32'd0);
         m_sf = er[31];
         m_of = ref_of(a, b, f);
      end
      chk({flag_zf, flag_sf, flag_of} == {m_zf, m_sf, m_of},
          sc ? "R6 R7" : "R8", {29'd0, flag_zf, flag_sf, flag_of}, {29'd0, m_zf, m_sf, m_of});
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5EED));
      repeat (3) @(posedge clk);
      #1;
      chk({flag_zf, flag_sf, flag_of} == 3'b100, "R5 in reset", {29'd0, flag_zf, flag_sf, flag_of}, 32'h4);
      @(negedge clk);
      rst_n = 1'b1;
      cond_fn = 3'd3;
      #1;
      chk({flag_zf, flag_sf, flag_of} == 3'b100, "R5 after release", {29'd0, flag_zf, flag_sf, flag_of}, 32'h4);
      chk(take == 1'b1, "R5 eq after reset", {31'd0, take}, 32'd1);

      // R4: result follows operands inside one low phase
      @(negedge clk);
      op_a = 32'd1; op_b = 32'd2; alu_fn = 2'd0; set_cc = 1'b0;
      #0.5;
      chk(result == 32'd3, "R4 first", result, 32'd3);
      op_a = 32'd5;
      #0.5;
      chk(result == 32'd7, "R4 second", result, 32'd7);
      alu_fn = 2'd3;
      #0.5;
      chk(result == 32'd7, "R4 fn change", result, 32'd7);

      // R1 R7 signed boundaries, add
      step(32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 1'b1, 3'd0);
      step(32'h8000_0000, 32'h8000_0000, 2'd0, 1'b1, 3'd2);
      step(32'h7FFF_FFFF, 32'h8000_0000, 2'd0, 1'b1, 3'd3);
      // R2 R7 signed boundaries, subtract
      step(32'h0000_0001, 32'h8000_0000, 2'd1, 1'b1, 3'd4);
      step(32'hFFFF_FFFF, 32'h7FFF_FFFF, 2'd1, 1'b1, 3'd5);
      step(32'h8000_0000, 32'h8000_0000, 2'd1, 1'b1, 3'd6);
      step(32'h7FFF_FFFF, 32'h7FFF_FFFE, 2'd1, 1'b1, 3'd1);
      // R7: logic op clears OF after an overflow
      step(32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 1'b1, 3'd0);
      step(32'hF0F0_0000, 32'h0F0F_0000, 2'd2, 1'b1, 3'd2);
      step(32'h8000_0000, 32'h0000_0001, 2'd3, 1'b1, 3'd5);
      // R8: no load keeps flags
      step(32'h0000_0000, 32'h0000_0000, 2'd0, 1'b0, 3'd3);
      // R10: zero result without load must not make eq true
      step(32'h0000_0005, 32'h0000_0003, 2'd1, 1'b1, 3'd0);
      step(32'h1234_5678, 32'h1234_5678, 2'd3, 1'b0, 3'd3);
      chk(take == 1'b0, "R10 eq stays false", {31'd0, take}, 32'd0);
      // R9: every code against a few flag states
      for (int s = 0; s < 3; s++) begin
         case (s)
            0: step(32'd4, 32'd4, 2'd1, 1'b1, 3'd0);
            1: step(32'd9, 32'd2, 2'd1, 1'b1, 3'd0);
            default: step(32'h0000_0001, 32'h8000_0000, 2'd1, 1'b1, 3'd0);
         endcase
         for (int c = 0; c < 8; c++) step(32'd0, 32'd0, 2'd2, 1'b0, 3'(c));
      end
      // random mix with boundary operands
      for (int i = 0; i < 400; i++) begin
         logic [31:0] ra, rb;
         ra = $urandom();
         rb = $urandom();
         case ($urandom_range(0, 5))
            0: ra = 32'h7FFF_FFFF;
            1: rb = 32'h8000_0000;
            2: ra = rb;
            default: ;
         endcase
         step(ra, rb, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule